// File: doc/BRIEF.md
# Way-Predicted Set-Associative Tag Lookup

This unit does the tag lookup for a small set-associative cache. Each set holds one way-guess field that names the way the next access to that set is expected to use. A lookup first compares the request tag against the guessed way only. If that way is valid and its tag matches, the unit reports a fast hit one clock after it accepts the request. This is the same latency a direct-mapped lookup would have.

If the guess is wrong, the unit spends a second cycle comparing the request tag against every other way of the set. That cycle ends in a slow hit or a miss. After a slow hit the guess for the set moves to the way that hit.

A fill port writes a tag into a chosen way, marks that way valid and points the set's guess at it. The refill engine that drives this port, the choice of victim way and the data array all sit outside the unit.

Top module: `wp_tag_lookup`

## Requirements
- R1: After reset, req_ready is 1, hit_fast, hit_slow and miss are 0, every way is invalid and every set's guess is way 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the edge that takes a request until its result is reported. req_valid asserted while req_ready is 0 has no effect.
- R3: If the guessed way is valid and its tag equals the request tag, hit_fast is 1 for one cycle, starting one clock after the accepting edge, with hit_way equal to the guessed way.
- R4: If the guess does not match but another valid way does, hit_slow is 1 for one cycle, starting two clocks after the accepting edge, with hit_way equal to the matching way. If several ways match, the lowest-numbered one is reported.
- R5: If no valid way matches, miss is 1 for one cycle, starting two clocks after the accepting edge, and hit_way is 0.
- R6: Each accepted request produces exactly one pulse on exactly one of hit_fast, hit_slow and miss. No two of these outputs are ever 1 in the same cycle.
- R7: After a slow hit, the guess of that set is the way that hit, so an immediate repeat of the same lookup gives a fast hit.
- R8: A fill (fill_valid 1 at an edge) stores fill_tag in way fill_way of set fill_index, marks that way valid and sets that set's guess to fill_way.
- R9: An invalid way never matches, even when its stored tag equals the request tag. Stored tags reset to 0.
- R10: A fast hit and a miss leave the set's guess unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_index | input | 4 | Set index of the request |
| req_tag | input | 8 | Tag of the request |
| req_ready | output | 1 | Unit can take a request this cycle |
| fill_valid | input | 1 | Write a tag into the arrays |
| fill_index | input | 4 | Set written by the fill |
| fill_way | input | 2 | Way written by the fill |
| fill_tag | input | 8 | Tag written by the fill |
| hit_fast | output | 1 | One-cycle pulse: guessed way hit |
| hit_slow | output | 1 | One-cycle pulse: another way hit |
| miss | output | 1 | One-cycle pulse: no valid way matched |
| hit_way | output | 2 | Way that hit, valid with hit_fast or hit_slow |

## Verification
The hardest case to reach is a set that holds the same tag in two ways while its guess points at a third way. Only that case tests the lowest-way rule of the slow compare. The stimulus builds it through the fill port alone. It fills the two duplicate ways first and the third way last, because the last fill moves the guess away from both duplicates. A related case covers the ignore rule. The driver keeps req_valid high through the busy cycle after a slow lookup is accepted, then checks that only one result arrives.

// File: rtl/wp_pkg.sv
// Shared types for the way-predicted tag lookup.
// Assumes: nothing beyond IEEE 1800-2017.
package wp_pkg;
    // Lookup sequencing: wait for request, check guessed way, scan the rest.
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_PRED = 2'd1,
        LK_SCAN = 2'd2
    } lk_state_t;
endpackage

// File: rtl/wp_tag_store.sv
// Tag and valid arrays, one fill write port, one whole-set read port.
// Assumes: a fill to the set being looked up is not issued mid-lookup.
module wp_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 8,
    localparam int IDX_W  = $clog2(SETS),
    localparam int PRED_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [PRED_W-1:0]           wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_valid
);
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tags_q;
    logic [SETS-1:0][WAYS-1:0]            valid_q;

    // Clear on reset; write one way of one set on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags_q  <= '0;
            valid_q <= '0;
        end else if (wr_en) begin
            tags_q[wr_idx][wr_way]  <= wr_tag;
            valid_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    // Present every way of the addressed set.
    always_comb begin
        rd_tags  = tags_q[rd_idx];
        rd_valid = valid_q[rd_idx];
    end
endmodule

// File: rtl/wp_pred_table.sv
// Per-set way-guess field with a correction port and a fill port.
// Assumes: the fill port wins when both write the same set in one cycle.
module wp_pred_table #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int IDX_W  = $clog2(SETS),
    localparam int PRED_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_en,
    input  logic [IDX_W-1:0]  fix_idx,
    input  logic [PRED_W-1:0] fix_way,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [PRED_W-1:0] fill_way,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PRED_W-1:0] rd_way
);
    logic [SETS-1:0][PRED_W-1:0] guess_q;

    // Reset every guess to way 0; apply correction, then fill (fill last wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guess_q <= '0;
        end else begin
            if (fix_en)  guess_q[fix_idx]  <= fix_way;
            if (fill_en) guess_q[fill_idx] <= fill_way;
        end
    end

    // Read the guess of the set under lookup.
    assign rd_way = guess_q[rd_idx];
endmodule

// File: rtl/wp_way_match.sv
// Tag comparators for one set: result for the guessed way, and the lowest
// matching way among all the others.
// Assumes: set_valid gates every comparator.
module wp_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int PRED_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           cmp_tag,
    input  logic [PRED_W-1:0]          guess_way,
    output logic                       guess_hit,
    output logic                       other_hit,
    output logic [PRED_W-1:0]          other_way
);
    logic [WAYS-1:0] hit_vec;
    logic [WAYS-1:0] guess_oh;
    logic [WAYS-1:0] other_vec;

    // One comparator per way, each gated by that way's valid bit.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_valid[w] && (set_tags[w] == cmp_tag);
    end

    // Split the compare result into the guessed way and the other ways.
    always_comb begin
        guess_oh            = '0;
        guess_oh[guess_way] = 1'b1;
        other_vec           = hit_vec & ~guess_oh;
        guess_hit           = hit_vec[guess_way];
        other_hit           = |other_vec;
    end

    // Priority encode the other ways, lowest index wins.
    always_comb begin
        other_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (other_vec[w]) other_way = PRED_W'(w);
        end
    end
endmodule

// File: rtl/wp_tag_lookup.sv
// Way-predicted tag lookup: guessed-way compare in the first cycle, the
// other ways in a second cycle when the guess is wrong.
// Assumes: one lookup in flight; a fill never targets the set under lookup.
module wp_tag_lookup #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 8,
    localparam int IDX_W  = $clog2(SETS),
    localparam int PRED_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_ready,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [PRED_W-1:0] fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              hit_fast,
    output logic              hit_slow,
    output logic              miss,
    output logic [PRED_W-1:0] hit_way
);
    import wp_pkg::*;

    lk_state_t                  state_q;
    logic [IDX_W-1:0]           idx_q;
    logic [TAG_W-1:0]           tag_q;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            set_valid;
    logic [PRED_W-1:0]          guess_way;
    logic                       guess_hit;
    logic                       other_hit;
    logic [PRED_W-1:0]          other_way;
    logic                       fix_en;

    wp_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_valid),
        .wr_idx   (fill_index),
        .wr_way   (fill_way),
        .wr_tag   (fill_tag),
        .rd_idx   (idx_q),
        .rd_tags  (set_tags),
        .rd_valid (set_valid)
    );

    wp_pred_table #(.WAYS(WAYS), .SETS(SETS)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .fix_en   (fix_en),
        .fix_idx  (idx_q),
        .fix_way  (other_way),
        .fill_en  (fill_valid),
        .fill_idx (fill_index),
        .fill_way (fill_way),
        .rd_idx   (idx_q),
        .rd_way   (guess_way)
    );

    wp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_tags  (set_tags),
        .set_valid (set_valid),
        .cmp_tag   (tag_q),
        .guess_way (guess_way),
        .guess_hit (guess_hit),
        .other_hit (other_hit),
        .other_way (other_way)
    );

    // Ready only while no lookup is in flight.
    assign req_ready = (state_q == LK_IDLE);

    // Move the guess to the way that hit in the second compare cycle.
    assign fix_en = (state_q == LK_SCAN) && other_hit;

    // Sequence the lookup and register the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LK_IDLE;
            idx_q    <= '0;
            tag_q    <= '0;
            hit_fast <= 1'b0;
            hit_slow <= 1'b0;
            miss     <= 1'b0;
            hit_way  <= '0;
        end else begin
            hit_fast <= 1'b0;
            hit_slow <= 1'b0;
            miss     <= 1'b0;
            unique case (state_q)
                LK_IDLE: begin
                    if (req_valid) begin
                        idx_q   <= req_index;
                        tag_q   <= req_tag;
                        state_q <= LK_PRED;
                    end
                end
                LK_PRED: begin
                    if (guess_hit) begin
                        hit_fast <= 1'b1;
                        hit_way  <= guess_way;
                        state_q  <= LK_IDLE;
                    end else begin
                        state_q  <= LK_SCAN;
                    end
                end
                LK_SCAN: begin
                    if (other_hit) begin
                        hit_slow <= 1'b1;
                        hit_way  <= other_way;
                    end else begin
                        miss     <= 1'b1;
                        hit_way  <= '0;
                    end
                    state_q <= LK_IDLE;
                end
                default: state_q <= LK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wp_tag_lookup_chk.sv
// Port-level protocol checks for wp_tag_lookup, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module wp_tag_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic hit_fast,
    input logic hit_slow,
    input logic miss
);
    // R6
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_fast, hit_slow, miss}));

    // R6
    status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_fast || hit_slow || miss) |=> !(hit_fast || hit_slow || miss));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    fast_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_fast |-> (req_ready && !$past(req_ready)));

    // R4
    slow_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_slow || miss) |-> (req_ready && !$past(req_ready) && !$past(req_ready, 2)));
endmodule

bind wp_tag_lookup wp_tag_lookup_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .hit_fast  (hit_fast),
    .hit_slow  (hit_slow),
    .miss      (miss)
);

// File: tb/tb_wp_tag_lookup.sv
// Scoreboard bench: the driver predicts each result from a requirement
// model and queues it; the monitor pops and compares result pulses.
module tb_wp_tag_lookup;
    localparam int WAYS = 4, SETS = 16, TAG_W = 8;
    localparam int K_FAST = 0, K_SLOW = 1, K_MISS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_index = '0;
    logic [7:0] req_tag = '0;
    logic       req_ready;
    logic       fill_valid = 1'b0;
    logic [3:0] fill_index = '0;
    logic [1:0] fill_way = '0;
    logic [7:0] fill_tag = '0;
    logic       hit_fast, hit_slow, miss;
    logic [1:0] hit_way;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int    q_kind[$];
    int    q_way[$];
    int    q_acc[$];
    string q_req[$];

    logic [7:0] m_tag [SETS][WAYS];
    bit         m_val [SETS][WAYS];
    int         m_pred[SETS];

    wp_tag_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_index(req_index), .req_tag(req_tag),
        .req_ready(req_ready),
        .fill_valid(fill_valid), .fill_index(fill_index),
        .fill_way(fill_way), .fill_tag(fill_tag),
        .hit_fast(hit_fast), .hit_slow(hit_slow), .miss(miss), .hit_way(hit_way)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: compare each result pulse with the queue head.
    always @(negedge clk) begin
        if (rst_n && (hit_fast || hit_slow || miss)) begin
            int k;
            k = hit_fast ? K_FAST : (hit_slow ? K_SLOW : K_MISS);
            if (q_kind.size() == 0) begin
                chk(1'b0, "R6", "unexpected result pulse", k, -1);
            end else begin
                int ek, ew, ea, lat;
                string er;
                ek = q_kind.pop_front();
                ew = q_way.pop_front();
                ea = q_acc.pop_front();
                er = q_req.pop_front();
                lat = (ek == K_FAST) ? 1 : 2;
                chk(k == ek, er, "result kind", k, ek);
                chk(int'(hit_way) == ew, er, "hit_way", hit_way, ew);
                chk(cyc - ea == lat, er, "latency", cyc - ea, lat);
            end
        end
    end

    // Model a fill per R8.
    task automatic do_fill(input int s, input int w, input logic [7:0] t);
        @(negedge clk);
        fill_valid = 1'b1; fill_index = 4'(s); fill_way = 2'(w); fill_tag = t;
        @(negedge clk);
        fill_valid = 1'b0;
        m_tag[s][w] = t; m_val[s][w] = 1'b1; m_pred[s] = w;
    endtask

    // Driver: predict result, issue request, optionally hold req_valid one busy cycle.
    task automatic lookup(input int s, input logic [7:0] t, input string req,
                          input bit hold_busy);
        int p, k, w;
        p = m_pred[s]; k = K_MISS; w = 0;
        if (m_val[s][p] && m_tag[s][p] == t) begin
            k = K_FAST; w = p;
        end else begin
            for (int i = WAYS - 1; i >= 0; i--)
                if (i != p && m_val[s][i] && m_tag[s][i] == t) begin k = K_SLOW; w = i; end
            if (k == K_SLOW) m_pred[s] = w;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_index = 4'(s); req_tag = t;
        q_kind.push_back(k); q_way.push_back(w);
        q_acc.push_back(cyc + 1); q_req.push_back(req);
        @(negedge clk);
        if (hold_busy) begin
            chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
            req_tag = t ^ 8'hFF;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (q_kind.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_pred[s] = 0;
            for (int w = 0; w < WAYS; w++) begin m_tag[s][w] = '0; m_val[s][w] = 1'b0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk({hit_fast, hit_slow, miss} == 3'b000, "R1", "status after reset",
            {hit_fast, hit_slow, miss}, 0);
        // R1 R5: empty arrays miss
        lookup(3, 8'h55, "R5", 1'b0);
        // R9: reset tag 0 in invalid ways must not match
        lookup(5, 8'h00, "R9", 1'b0);
        // R8 R3: fill way 0, guess stays way 0, fast hit
        do_fill(3, 0, 8'h55);
        lookup(3, 8'h55, "R3", 1'b0);
        // R8: fill way 2 moves guess to way 2, fast hit there
        do_fill(3, 2, 8'hA1);
        lookup(3, 8'hA1, "R8", 1'b0);
        // R4 then R7: wrong guess gives slow hit, repeat gives fast hit
        lookup(3, 8'h55, "R4", 1'b0);
        lookup(3, 8'h55, "R7", 1'b0);
        lookup(3, 8'hA1, "R4", 1'b0);
        lookup(3, 8'hA1, "R7", 1'b0);
        // R10: a miss leaves the guess on way 2, next lookup fast
        lookup(3, 8'h77, "R5", 1'b0);
        lookup(3, 8'hA1, "R10", 1'b0);
        // R4: duplicates in ways 1 and 3 with guess on way 0 report way 1
        do_fill(7, 3, 8'h33);
        do_fill(7, 1, 8'h33);
        do_fill(7, 0, 8'h10);
        lookup(7, 8'h33, "R4", 1'b0);
        // R2: req_valid held during busy cycle is ignored, one result only
        do_fill(9, 0, 8'h20);
        do_fill(9, 2, 8'h21);
        lookup(9, 8'h20, "R2", 1'b1);
        repeat (4) @(negedge clk);
        chk(q_kind.size() == 0 && req_ready, "R2", "no second lookup after ignored request",
            q_kind.size(), 0);
        lookup(9, 8'h20, "R7", 1'b0);
        // R8: overwrite way 2 of set 3, old tag then misses
        do_fill(3, 2, 8'h44);
        lookup(3, 8'hA1, "R8", 1'b0);
        lookup(3, 8'h44, "R3", 1'b0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule